// File: doc/BRIEF.md
# Memory-Mapped Dual Timer/Counter

This peripheral holds one or two 32-bit timers. A build-time parameter picks how many. They sit behind a simple 32-bit register bus that only accepts whole, aligned words. Each timer has three registers: control/status, load value and live count. The count engine starts from the load value and can count either up or down. On expiry it sets the timer's interrupt flag. After that the timer either reloads itself and keeps running, or stops.

All timers drive one level-sensitive interrupt output. That output is high while any timer has both its flag and its interrupt enable set. Software arms a timer by writing the control word with the enable bit set. It acknowledges an interrupt by writing the control word with the flag bit set. Several mode bits are stored and read back but have no effect on counting.

The bus is a single-cycle request. A write takes effect at the clock edge that samples it. Read data and a read-valid strobe appear registered, one cycle after the request.

Top module: `dtc_top`

## Requirements
- R1: After reset every register of every timer reads zero, no timer counts and `irq_o` is low.
- R2: Timer i occupies byte addresses 16*i to 16*i+15: control/status at offset 0x0, load at 0x4, count at 0x8, reserved at 0xC. A read is answered with `rvalid_o` one cycle later. Reads of the reserved word, of an address above 16*NUM_TIMERS or of an address with nonzero bits [1:0] return zero, and writes there change nothing.
- R3: Control/status keeps only bits [10:0]; bits [31:11] read zero. Bits 0 (mode), 2 (generate), 3 (capture), 5 (load), 9 (PWM) and 10 (all-enable) are stored and read back but do not affect counting or the interrupt.
- R4: Writing control/status with bit 7 (enable) set copies the load register into the count and starts counting from the next clock.
- R5: With bit 1 = 1 the count drops by one per clock. It expires at the edge where a running count equals zero, which is L+1 clocks after arming with load L.
- R6: With bit 1 = 0 the count rises by one per clock. It expires at the edge where a running count equals 0xFFFFFFFF, the wrap.
- R7: On expiry bit 8 (flag) is set. With bit 4 (auto-reload) set, the count reloads from the load register and keeps running. Otherwise the count freezes and stays put until the next arming write.
- R8: Writing control/status with bit 8 = 1 clears the flag. Writing it with bit 8 = 0 leaves the flag unchanged.
- R9: `irq_o` is the OR over all timers of flag AND bit 6 (interrupt enable), and it follows every write and every expiry.
- R10: When an expiry and a control/status write to the same timer hit the same edge, the flag ends up set, whatever bit 8 of the written value.
- R11: The count register reads the live count. Writes to it are ignored.
- R12: NUM_TIMERS (1 or 2) sets the number of timers. Timers count and flag independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| irq_o | output | 1 | Shared level interrupt |

## Verification
Two events can land on the same edge: a timer expiring, and software writing that timer's control word. The expiry wants to set the flag, while the write either clears it or rewrites the other control bits. The bench arms a down-counting timer with a small load, so it knows the exact expiry edge. It then times a control write to land on that edge, once with bit 8 clear and once with bit 8 set. In both cases `irq_o` and the control readback must show the flag still set afterwards.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int WORD_W = 32;
  localparam int CTRL_W = 11;

  // control/status bit positions
  localparam int CB_MODE = 0;
  localparam int CB_DOWN = 1;
  localparam int CB_GEN  = 2;
  localparam int CB_CAP  = 3;
  localparam int CB_ARLD = 4;
  localparam int CB_LDB  = 5;
  localparam int CB_IE   = 6;
  localparam int CB_EN   = 7;
  localparam int CB_FLAG = 8;
  localparam int CB_PWM  = 9;
  localparam int CB_ALL  = 10;

  typedef enum logic [1:0] {
    SLOT_CTRL  = 2'd0,
    SLOT_LOAD  = 2'd1,
    SLOT_COUNT = 2'd2,
    SLOT_RSVD  = 2'd3
  } slot_e;
endpackage

// File: rtl/dtc_decode.sv
module dtc_decode #(
  parameter int NUM_TIMERS = 2,
  parameter int ADDR_W     = 8
) (
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  output logic [NUM_TIMERS-1:0] wr_sel_o,
  output logic [NUM_TIMERS-1:0] rd_sel_o,
  output dtc_pkg::slot_e        slot_o
);
  localparam int TIDX_W = ADDR_W - 4;

  logic              aligned;
  logic [TIDX_W-1:0] tidx;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign tidx    = addr_i[ADDR_W-1:4];
  assign slot_o  = dtc_pkg::slot_e'(addr_i[3:2]);

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_sel
    logic hit;
    assign hit         = req_i && aligned && (tidx == TIDX_W'(i));
    assign wr_sel_o[i] = hit && we_i;
    assign rd_sel_o[i] = hit && !we_i;
  end
endmodule

// File: rtl/dtc_channel.sv
module dtc_channel
  import dtc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  slot_e             slot_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  load_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              run_o,
  output logic              expire_o,
  output logic              irq_o
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_nx;
  logic [CNT_W-1:0]  load_q, cnt_q, cnt_nx, term;
  logic              live_q, live_nx;
  logic              run, expire, ctrl_wr, load_wr, flag_nx;

  assign ctrl_wr = wr_i && (slot_i == SLOT_CTRL);
  assign load_wr = wr_i && (slot_i == SLOT_LOAD);
  assign run     = ctrl_q[CB_EN] && live_q;
  assign term    = ctrl_q[CB_DOWN] ? '0 : '1;
  assign expire  = run && (cnt_q == term);

  // flag: expiry in the same cycle always wins over a clear
  always_comb begin
    ctrl_nx = ctrl_q;
    flag_nx = ctrl_q[CB_FLAG] | expire;
    if (ctrl_wr) begin
      ctrl_nx = wdata_i[CTRL_W-1:0];
      if (wdata_i[CB_FLAG]) flag_nx = expire;
    end
    ctrl_nx[CB_FLAG] = flag_nx;
  end

  always_comb begin
    cnt_nx  = cnt_q;
    live_nx = live_q;
    if (ctrl_wr && wdata_i[CB_EN]) begin
      cnt_nx  = load_q;
      live_nx = 1'b1;
    end else if (expire) begin
      if (ctrl_q[CB_ARLD]) cnt_nx = load_q;
      else                 live_nx = 1'b0;
    end else if (run) begin
      cnt_nx = ctrl_q[CB_DOWN] ? cnt_q - 1'b1 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      load_q <= '0;
      cnt_q  <= '0;
      live_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_nx;
      cnt_q  <= cnt_nx;
      live_q <= live_nx;
      if (load_wr) load_q <= wdata_i;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign load_o   = load_q;
  assign cnt_o    = cnt_q;
  assign run_o    = run;
  assign expire_o = expire;
  assign irq_o    = ctrl_q[CB_FLAG] && ctrl_q[CB_IE];
endmodule

// File: rtl/dtc_readmux.sv
module dtc_readmux
  import dtc_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int CNT_W      = 32
) (
  input  logic [NUM_TIMERS-1:0]             rd_sel_i,
  input  slot_e                             slot_i,
  input  logic [NUM_TIMERS-1:0][CTRL_W-1:0] ctrl_i,
  input  logic [NUM_TIMERS-1:0][CNT_W-1:0]  load_i,
  input  logic [NUM_TIMERS-1:0][CNT_W-1:0]  cnt_i,
  output logic [CNT_W-1:0]                  data_o
);
  always_comb begin
    data_o = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (rd_sel_i[i]) begin
        case (slot_i)
          SLOT_CTRL:  data_o = CNT_W'(ctrl_i[i]);
          SLOT_LOAD:  data_o = load_i[i];
          SLOT_COUNT: data_o = cnt_i[i];
          default:    data_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dtc_top.sv
module dtc_top
  import dtc_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int ADDR_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o,
  output logic              irq_o
);
  localparam int CNT_W = WORD_W;

  logic [NUM_TIMERS-1:0]             wr_sel, rd_sel;
  slot_e                             slot;
  logic [NUM_TIMERS-1:0][CTRL_W-1:0] ctrl_w;
  logic [NUM_TIMERS-1:0][CNT_W-1:0]  load_w, cnt_w;
  logic [NUM_TIMERS-1:0]             run_w, expire_w, flag_w, irq_w;
  logic [CNT_W-1:0]                  rd_data;
  logic [CNT_W-1:0]                  rdata_q;
  logic                              rvalid_q;

  dtc_decode #(.NUM_TIMERS(NUM_TIMERS), .ADDR_W(ADDR_W)) u_dec (
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wr_sel_o(wr_sel),
    .rd_sel_o(rd_sel),
    .slot_o  (slot)
  );

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    dtc_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_sel[i]),
      .slot_i  (slot),
      .wdata_i (wdata_i),
      .ctrl_o  (ctrl_w[i]),
      .load_o  (load_w[i]),
      .cnt_o   (cnt_w[i]),
      .run_o   (run_w[i]),
      .expire_o(expire_w[i]),
      .irq_o   (irq_w[i])
    );
    assign flag_w[i] = ctrl_w[i][CB_FLAG];
  end

  dtc_readmux #(.NUM_TIMERS(NUM_TIMERS), .CNT_W(CNT_W)) u_rmux (
    .rd_sel_i(rd_sel),
    .slot_i  (slot),
    .ctrl_i  (ctrl_w),
    .load_i  (load_w),
    .cnt_i   (cnt_w),
    .data_o  (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= req_i && !we_i;
      rdata_q  <= (req_i && !we_i) ? rd_data : '0;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign irq_o    = |irq_w;
endmodule

// File: rtl/dtc_checker.sv
module dtc_checker #(
  parameter int NUM_TIMERS = 2
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            req_i,
  input logic                            we_i,
  input logic [3:0]                      addr_lo_i,
  input logic [31:0]                     rdata_o,
  input logic                            rvalid_o,
  input logic                            irq_o,
  input logic [NUM_TIMERS-1:0]           run_w,
  input logic [NUM_TIMERS-1:0]           expire_w,
  input logic [NUM_TIMERS-1:0]           flag_w,
  input logic [NUM_TIMERS-1:0][31:0]     cnt_w
);
  AST_READ_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i |=> rvalid_o); // R2

  AST_MISALIGNED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && (addr_lo_i[1:0] != 2'b00) |=> rdata_o == 32'h0); // R2

  AST_CTRL_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && (addr_lo_i[3:2] == 2'd0) |=> rdata_o[31:11] == '0); // R3

  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(req_i && we_i) || $past(|expire_w))); // R9

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chk
    AST_EXPIRE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_w[i] |=> flag_w[i]); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_w[i] && !(req_i && we_i) |=> $stable(cnt_w[i])); // R7
  end
endmodule

bind dtc_top dtc_checker #(.NUM_TIMERS(NUM_TIMERS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_lo_i(addr_i[3:0]),
  .rdata_o  (rdata_o),
  .rvalid_o (rvalid_o),
  .irq_o    (irq_o),
  .run_w    (run_w),
  .expire_w (expire_w),
  .flag_w   (flag_w),
  .cnt_w    (cnt_w)
);

// File: tb/tb_dtc_top.sv
`timescale 1ns/1ps
module tb_dtc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, irq;
  int          n_chk = 0, n_err = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  dtc_top #(.NUM_TIMERS(2), .ADDR_W(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; the access is sampled at the following posedge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
    chk("R2 rvalid", {31'b0, rvalid}, 32'h1);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd(8'h00, d); chk("R1 ctrl0", d, 32'h0);
    rd(8'h04, d); chk("R1 load0", d, 32'h0);
    rd(8'h08, d); chk("R1 count0", d, 32'h0);
    rd(8'h10, d); chk("R1 ctrl1", d, 32'h0);
  endtask

  task automatic t_decode;
    logic [31:0] d;
    wr(8'h04, 32'hA5A5_0001);
    rd(8'h04, d); chk("R2 load0 readback", d, 32'hA5A5_0001);
    wr(8'h05, 32'h0000_1111);
    rd(8'h04, d); chk("R2 misaligned write ignored", d, 32'hA5A5_0001);
    rd(8'h05, d); chk("R2 misaligned read zero", d, 32'h0);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, d); chk("R2 reserved reads zero", d, 32'h0);
    rd(8'h20, d); chk("R2 absent timer zero", d, 32'h0);
    wr(8'h14, 32'h77);
    rd(8'h14, d); chk("R2 load1 readback", d, 32'h77);
    rd(8'h04, d); chk("R2 load0 untouched", d, 32'hA5A5_0001);
  endtask

  task automatic t_ctrl_bits;
    logic [31:0] d;
    wr(8'h00, 32'hFFFF_FA21);
    rd(8'h00, d); chk("R3 ctrl low 11 bits kept", d, 32'h0000_0221);
    chk("R3 inert bits no irq", {31'b0, irq}, 32'h0);
    rd(8'h08, d); chk("R3 inert bits no count", d, 32'h0);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_count_write;
    logic [31:0] d;
    wr(8'h08, 32'h1234);
    rd(8'h08, d); chk("R11 count write ignored", d, 32'h0);
  endtask

  task automatic t_live_count;
    logic [31:0] d, e;
    wr(8'h04, 32'd100);
    wr(8'h00, 32'h82);
    rd(8'h08, d); chk("R4 count loaded", d, 32'd100);
    idle(9);
    rd(8'h08, d); chk("R11 live count down", d, 32'd90);
    wr(8'h00, 32'h100);
    rd(8'h08, d); rd(8'h08, e);
    chk("R7 stopped count holds", e, d);
  endtask

  task automatic t_down_oneshot;
    logic [31:0] d;
    wr(8'h04, 32'd3);
    wr(8'h00, 32'hC2);
    idle(3); chk("R5 no expiry before zero", {31'b0, irq}, 32'h0);
    idle(1); chk("R5 expiry at zero", {31'b0, irq}, 32'h1);
    idle(3);
    rd(8'h08, d); chk("R7 one-shot stops at zero", d, 32'h0);
    rd(8'h00, d); chk("R7 flag set", d, 32'h1C2);
    wr(8'h00, 32'h100);
    chk("R8 flag clear drops irq", {31'b0, irq}, 32'h0);
    rd(8'h00, d); chk("R8 ctrl after clear", d, 32'h0);
  endtask

  task automatic t_up_reload;
    logic [31:0] d;
    wr(8'h04, 32'hFFFF_FFFD);
    wr(8'h00, 32'hD0);
    idle(2); chk("R6 no expiry before wrap", {31'b0, irq}, 32'h0);
    idle(1); chk("R6 expiry at wrap", {31'b0, irq}, 32'h1);
    rd(8'h08, d); chk("R7 auto-reload", d, 32'hFFFF_FFFD);
    rd(8'h08, d); chk("R7 keeps running", d, 32'hFFFF_FFFE);
    wr(8'h00, 32'h100);
    chk("R8 clear after reload", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_mask;
    wr(8'h04, 32'd0);
    wr(8'h00, 32'h82);
    idle(2); chk("R9 flag masked by ie=0", {31'b0, irq}, 32'h0);
    wr(8'h00, 32'h40);
    chk("R8 bit8=0 keeps flag", {31'b0, irq}, 32'h1);
    wr(8'h00, 32'h140);
    chk("R8 bit8=1 clears flag", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_same_cycle;
    logic [31:0] d;
    wr(8'h04, 32'd2);
    wr(8'h00, 32'hC2);
    idle(2);
    wr(8'h00, 32'h042);
    chk("R10 expiry with write bit8=0", {31'b0, irq}, 32'h1);
    wr(8'h00, 32'h100);
    wr(8'h00, 32'hC2);
    idle(2);
    wr(8'h00, 32'h142);
    chk("R10 expiry beats clear", {31'b0, irq}, 32'h1);
    rd(8'h00, d); chk("R10 flag kept in ctrl", d, 32'h142);
    wr(8'h00, 32'h100);
    chk("R10 later clear works", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_two_timers;
    logic [31:0] d;
    wr(8'h14, 32'd1);
    wr(8'h10, 32'hC2);
    idle(2); chk("R12 timer1 irq", {31'b0, irq}, 32'h1);
    rd(8'h10, d); chk("R12 timer1 ctrl", d, 32'h1C2);
    rd(8'h00, d); chk("R12 timer0 untouched", d, 32'h0);
    wr(8'h04, 32'd0);
    wr(8'h00, 32'hC2);
    idle(2);
    wr(8'h10, 32'h100);
    chk("R9 OR keeps timer0 irq", {31'b0, irq}, 32'h1);
    wr(8'h00, 32'h100);
    chk("R9 all clear", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    #200_000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_decode();
    t_ctrl_bits();
    t_count_write();
    t_live_count();
    t_down_oneshot();
    t_up_reload();
    t_mask();
    t_same_cycle();
    t_two_timers();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule